// File: doc/BRIEF.md
# Host Command Decoder with Configuration Registers

This block sits between a bus master and a memory command sequencer. The host presents a 3-bit command code with an address word for one cycle. The block turns each accepted memory command into a one-cycle request to the sequencer. When the sequencer reports completion, the block answers the host with a one-cycle acknowledge. After every acknowledge comes one mandatory idle cycle.

Two command codes never reach the sequencer. They load controller-internal registers instead. The timing register holds CAS latency, RAS-to-CAS delay, refresh command duration and burst length. The interval register holds the refresh period.

A down-counter reloads from the interval register each time it expires and sets a pending-refresh flag. While that flag is set, the block issues its own refresh request to the sequencer ahead of any host command. The flag clears when that refresh completes. The block drives no memory pins, times no inter-command delays and moves no data.

Top module: `host_cmd_decoder`

## Requirements
- R1: After reset, no request, acknowledge, refresh acknowledge, pending flag or error flag is active. The configuration outputs read CAS latency 2, RAS-to-CAS 2, refresh duration 8, burst length 4 and refresh interval 780.
- R2: Codes 001 (read, auto-precharge), 010 (write, auto-precharge), 011 (refresh), 100 (precharge all) and 101 (load mode register) can be presented while the block is idle with no refresh pending. In that case `seq_req_o` is high for exactly the next cycle, and `seq_op_o` carries the code. `seq_addr_o` carries the address word given with the command; for code 101 this word is the mode register value.
- R3: For a host memory command, `cmd_ack_o` is high for exactly one cycle, in the cycle after the one in which `seq_done_i` was high.
- R4: Code 110 loads the timing register from the address word and raises `cmd_ack_o` in the next cycle, with no sequencer request. The fields are: bits 1:0 CAS latency, bits 3:2 RAS-to-CAS delay, bits 7:4 refresh duration, bits 9:8 burst code.
- R5: The burst code decodes 01 to 2, 10 to 4 and 11 to 8. A timing-register load whose burst code is 00 keeps the previous burst length and still updates the other fields.
- R6: Code 111 loads the refresh interval N from address bits 11:0 and restarts the counter. If the load is presented in cycle T, `ref_pend_o` first rises in cycle T+N+1 and expires again every N cycles. N = 0 stops refresh generation.
- R7: While idle with `ref_pend_o` high, the block requests code 011 from the sequencer and gives no `cmd_ack_o`. In the cycle after `seq_done_i`, `ref_ack_o` pulses and `ref_pend_o` is low.
- R8: A host command presented in an idle cycle in which `ref_pend_o` is high is ignored: the refresh request is issued instead.
- R9: A non-zero code presented while a command is outstanding, during its acknowledge cycle or during the idle cycle after it, is ignored. It does not change the registers, does not produce a request and does not disturb the access in flight. Any ignored command (see also R8) sets `proto_err_o`, which stays high until reset.
- R10: Code 000 produces no request or acknowledge, and does not disturb an access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Host command code |
| addr_i | input | 16 | Host address / data word |
| seq_done_i | input | 1 | Sequencer finished the current request |
| cmd_ack_o | output | 1 | One-cycle acknowledge to the host |
| proto_err_o | output | 1 | Sticky protocol-error flag |
| seq_req_o | output | 1 | One-cycle request to the sequencer |
| seq_op_o | output | 3 | Requested operation code |
| seq_addr_o | output | 16 | Address word for the request |
| ref_pend_o | output | 1 | Periodic refresh pending |
| ref_ack_o | output | 1 | Pulse when an internal refresh completes |
| cas_lat_o | output | 2 | CAS latency in clocks |
| trcd_o | output | 2 | RAS-to-CAS delay in clocks |
| trfc_o | output | 4 | Refresh command duration in clocks |
| burst_len_o | output | 4 | Decoded burst length |
| ref_interval_o | output | 12 | Refresh interval in clocks |

## Verification
The assertions check, on every cycle, that requests and acknowledges are single pulses and that no request follows an acknowledge. They also check that every acknowledge has a cause, that the error and pending flags hold until their clearing events, that the burst code never becomes illegal, and that a disabled interval never raises a refresh. The bench scenarios cover everything that depends on values and exact cycle counts. That includes the field decode of both register loads, the address forwarded with each request, the exact expiry cycle of the refresh counter, and the precedence of a pending refresh over a host command. It also includes proof that a rejected command leaves the registers untouched.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
  localparam logic [2:0] CMD_NOP  = 3'd0;
  localparam logic [2:0] CMD_RDA  = 3'd1;
  localparam logic [2:0] CMD_WRA  = 3'd2;
  localparam logic [2:0] CMD_REF  = 3'd3;
  localparam logic [2:0] CMD_PRE  = 3'd4;
  localparam logic [2:0] CMD_LMR  = 3'd5;
  localparam logic [2:0] CMD_CFG1 = 3'd6;
  localparam logic [2:0] CMD_CFG2 = 3'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACK, ST_GUARD} hcd_state_e;

  typedef struct packed {
    logic [1:0] bl_code;
    logic [3:0] trfc;
    logic [1:0] trcd;
    logic [1:0] cas;
  } cfg1_t;

  localparam cfg1_t CFG1_RST = '{bl_code: 2'b10, trfc: 4'd8, trcd: 2'd2, cas: 2'd2};

  function automatic logic [3:0] burst_len(input logic [1:0] code);
    case (code)
      2'b01:   burst_len = 4'd2;
      2'b11:   burst_len = 4'd8;
      default: burst_len = 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/hcd_cfg_regs.sv
module hcd_cfg_regs
  import hcd_pkg::*;
#(
  parameter int AW     = 16,
  parameter int RW     = 12,
  parameter int RW_RST = 780
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr1_i,
  input  logic          wr2_i,
  input  logic [AW-1:0] data_i,
  output logic [1:0]    cas_lat_o,
  output logic [1:0]    trcd_o,
  output logic [3:0]    trfc_o,
  output logic [3:0]    burst_len_o,
  output logic [RW-1:0] interval_o,
  output logic [RW-1:0] interval_nxt_o
);
  localparam int CFG1_W = $bits(cfg1_t);

  cfg1_t         cfg1_q;
  cfg1_t         cfg1_in;
  logic [RW-1:0] cfg2_q;
  logic [RW-1:0] cfg2_in;

  // interval field width versus address width
  generate
    if (RW <= AW) begin : g_trunc
      assign cfg2_in = data_i[RW-1:0];
    end else begin : g_zext
      assign cfg2_in = {{(RW-AW){1'b0}}, data_i};
    end
  endgenerate

  always_comb begin
    cfg1_in = cfg1_t'(data_i[CFG1_W-1:0]);
    if (cfg1_in.bl_code == 2'b00) cfg1_in.bl_code = cfg1_q.bl_code;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg1_q <= CFG1_RST;
      cfg2_q <= RW'(RW_RST);
    end else begin
      if (wr1_i) cfg1_q <= cfg1_in;
      if (wr2_i) cfg2_q <= cfg2_in;
    end
  end

  assign cas_lat_o      = cfg1_q.cas;
  assign trcd_o         = cfg1_q.trcd;
  assign trfc_o         = cfg1_q.trfc;
  assign burst_len_o    = burst_len(cfg1_q.bl_code);
  assign interval_o     = cfg2_q;
  assign interval_nxt_o = cfg2_in;

  assert_bl_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg1_q.bl_code != 2'b00);
  assert_cfg1_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr1_i |=> $stable(cfg1_q));
  assert_cfg2_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr2_i |=> $stable(cfg2_q));
endmodule

// File: rtl/hcd_refresh_timer.sv
module hcd_refresh_timer #(
  parameter int RW     = 12,
  parameter int RW_RST = 780
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] interval_i,
  input  logic          reload_i,
  input  logic [RW-1:0] reload_val_i,
  input  logic          clr_i,
  output logic          pend_o
);
  logic [RW-1:0] cnt_q;
  logic          expire;

  assign expire = !reload_i && (interval_i != '0) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= RW'(RW_RST - 1);
      pend_o <= 1'b0;
    end else begin
      if (reload_i)
        cnt_q <= (reload_val_i == '0) ? '0 : reload_val_i - 1'b1;
      else if (interval_i == '0)
        cnt_q <= '0;
      else if (cnt_q == '0)
        cnt_q <= interval_i - 1'b1;
      else
        cnt_q <= cnt_q - 1'b1;

      // a fresh expiry wins over a clear in the same cycle
      if (expire)     pend_o <= 1'b1;
      else if (clr_i) pend_o <= 1'b0;
    end
  end

  assert_pend_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !clr_i |=> pend_o);
  assert_no_pend_disabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interval_i == '0) && !pend_o |=> !pend_o);
endmodule

// File: rtl/hcd_cmd_fsm.sv
module hcd_cmd_fsm
  import hcd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic          seq_done_i,
  input  logic          pend_i,
  output logic          seq_req_o,
  output logic [2:0]    seq_op_o,
  output logic [AW-1:0] seq_addr_o,
  output logic          cmd_ack_o,
  output logic          ref_ack_o,
  output logic          ref_clr_o,
  output logic          wr1_o,
  output logic          wr2_o,
  output logic          err_o
);
  hcd_state_e st_q;
  logic       int_q;
  logic       host_cmd, is_idle, take_ref, take_host, is_load, bad;

  assign host_cmd  = cmd_i != CMD_NOP;
  assign is_idle   = st_q == ST_IDLE;
  assign is_load   = cmd_i[2:1] == 2'b11;
  assign take_ref  = is_idle && pend_i;
  assign take_host = is_idle && !pend_i && host_cmd;
  assign bad       = host_cmd && !take_host;
  assign wr1_o     = take_host && cmd_i == CMD_CFG1;
  assign wr2_o     = take_host && cmd_i == CMD_CFG2;
  assign ref_clr_o = st_q == ST_WAIT && int_q && seq_done_i;
  assign cmd_ack_o = st_q == ST_ACK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      int_q      <= 1'b0;
      seq_req_o  <= 1'b0;
      seq_op_o   <= CMD_NOP;
      seq_addr_o <= '0;
      ref_ack_o  <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      seq_req_o <= 1'b0;
      ref_ack_o <= 1'b0;
      if (bad) err_o <= 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          if (take_ref) begin
            seq_op_o   <= CMD_REF;
            seq_addr_o <= '0;
            int_q      <= 1'b1;
            seq_req_o  <= 1'b1;
            st_q       <= ST_WAIT;
          end else if (take_host) begin
            if (is_load) begin
              st_q <= ST_ACK;
            end else begin
              seq_op_o   <= cmd_i;
              seq_addr_o <= addr_i;
              int_q      <= 1'b0;
              seq_req_o  <= 1'b1;
              st_q       <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (seq_done_i) begin
            if (int_q) begin
              ref_ack_o <= 1'b1;
              st_q      <= ST_IDLE;
            end else begin
              st_q <= ST_ACK;
            end
          end
        end
        ST_ACK:   st_q <= ST_GUARD;
        ST_GUARD: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assert_ack_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ack_o |=> !cmd_ack_o && !seq_req_o);
  assert_req_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_req_o |=> !seq_req_o);
  assert_ack_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_ack_o) |-> $past(seq_done_i) || $past(wr1_o) || $past(wr2_o));
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_ref_ack_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ack_o |-> $past(seq_done_i) && !cmd_ack_o);
  assert_ref_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_idle && pend_i |=> seq_req_o && seq_op_o == CMD_REF);
endmodule

// File: rtl/host_cmd_decoder.sv
module host_cmd_decoder
  import hcd_pkg::*;
#(
  parameter int AW     = 16,
  parameter int RW     = 12,
  parameter int RW_RST = 780
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic          seq_done_i,
  output logic          cmd_ack_o,
  output logic          proto_err_o,
  output logic          seq_req_o,
  output logic [2:0]    seq_op_o,
  output logic [AW-1:0] seq_addr_o,
  output logic          ref_pend_o,
  output logic          ref_ack_o,
  output logic [1:0]    cas_lat_o,
  output logic [1:0]    trcd_o,
  output logic [3:0]    trfc_o,
  output logic [3:0]    burst_len_o,
  output logic [RW-1:0] ref_interval_o
);
  logic          wr1, wr2, ref_clr;
  logic [RW-1:0] interval_nxt;

  hcd_cmd_fsm #(.AW(AW)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd_i),
    .addr_i     (addr_i),
    .seq_done_i (seq_done_i),
    .pend_i     (ref_pend_o),
    .seq_req_o  (seq_req_o),
    .seq_op_o   (seq_op_o),
    .seq_addr_o (seq_addr_o),
    .cmd_ack_o  (cmd_ack_o),
    .ref_ack_o  (ref_ack_o),
    .ref_clr_o  (ref_clr),
    .wr1_o      (wr1),
    .wr2_o      (wr2),
    .err_o      (proto_err_o)
  );

  hcd_cfg_regs #(.AW(AW), .RW(RW), .RW_RST(RW_RST)) i_cfg (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr1_i          (wr1),
    .wr2_i          (wr2),
    .data_i         (addr_i),
    .cas_lat_o      (cas_lat_o),
    .trcd_o         (trcd_o),
    .trfc_o         (trfc_o),
    .burst_len_o    (burst_len_o),
    .interval_o     (ref_interval_o),
    .interval_nxt_o (interval_nxt)
  );

  hcd_refresh_timer #(.RW(RW), .RW_RST(RW_RST)) i_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .interval_i   (ref_interval_o),
    .reload_i     (wr2),
    .reload_val_i (interval_nxt),
    .clr_i        (ref_clr),
    .pend_o       (ref_pend_o)
  );

  assert_ack_req_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_ack_o && seq_req_o));
endmodule

// File: tb/test_host_cmd_decoder.sv
module test_host_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cmd;
  logic [15:0] addr;
  logic        done;
  logic        cmd_ack, perr, req, pend, rack;
  logic [2:0]  op;
  logic [15:0] saddr;
  logic [1:0]  cas, trcd;
  logic [3:0]  trfc, bl;
  logic [11:0] intv;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // model of the configuration state
  int m_cas, m_trcd, m_trfc, m_blc, m_int;

  always #10 clk = ~clk;

  host_cmd_decoder i_host_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .addr_i(addr), .seq_done_i(done),
    .cmd_ack_o(cmd_ack), .proto_err_o(perr), .seq_req_o(req), .seq_op_o(op),
    .seq_addr_o(saddr), .ref_pend_o(pend), .ref_ack_o(rack), .cas_lat_o(cas),
    .trcd_o(trcd), .trfc_o(trfc), .burst_len_o(bl), .ref_interval_o(intv)
  );

  function automatic int bl_of(input int c);
    case (c)
      1: return 2;
      3: return 8;
      default: return 4;
    endcase
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_cfg(input string tag);
    chk({tag, " cas"}, cas, m_cas);
    chk({tag, " trcd"}, trcd, m_trcd);
    chk({tag, " trfc"}, trfc, m_trfc);
    chk({tag, " burst"}, bl, bl_of(m_blc));
    chk({tag, " interval"}, intv, m_int);
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; cmd = 3'd0; addr = 16'd0; done = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    m_cas = 2; m_trcd = 2; m_trfc = 8; m_blc = 2; m_int = 780;
    tick();
  endtask

  task automatic do_load(input logic [2:0] code, input logic [15:0] a);
    cmd = code; addr = a;
    tick();
    cmd = 3'd0;
    chk("R4 load ack", cmd_ack, 1);
    chk("R4 load no req", req, 0);
    if (code == 3'd6) begin
      m_cas = a[1:0]; m_trcd = a[3:2]; m_trfc = a[7:4];
      if (a[9:8] != 2'b00) m_blc = a[9:8];
    end else begin
      m_int = a[11:0];
    end
    tick();
    chk("R3 ack single", cmd_ack, 0);
    check_cfg("R4 R5 R6 cfg");
    tick();
  endtask

  task automatic do_mem(input logic [2:0] code, input logic [15:0] a,
                        input int dly, input bit poke);
    cmd = code; addr = a;
    tick();
    cmd = 3'd0;
    chk("R2 req", req, 1);
    chk("R2 op", op, code);
    chk("R2 addr", saddr, a);
    chk("R3 no early ack", cmd_ack, 0);
    for (int i = 0; i < dly; i++) begin
      if (poke && i == 0) begin cmd = 3'd6; addr = 16'h03FF; end
      tick();
      cmd = 3'd0;
      chk("R2 R9 req single", req, 0);
      chk("R3 R10 no ack while busy", cmd_ack, 0);
    end
    done = 1'b1;
    tick();
    done = 1'b0;
    chk("R3 ack after done", cmd_ack, 1);
    tick();
    chk("R3 ack single", cmd_ack, 0);
    chk("R9 no req in guard", req, 0);
    tick();
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    reset_dut();
    // R1
    chk("R1 ack", cmd_ack, 0);
    chk("R1 req", req, 0);
    chk("R1 err", perr, 0);
    chk("R1 pend", pend, 0);
    chk("R1 ref_ack", rack, 0);
    check_cfg("R1");

    do_load(3'd7, 16'd0);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R10 nop idle req", req, 0);
      chk("R10 nop idle ack", cmd_ack, 0);
    end
    do_mem(3'd5, 16'h0123, 2, 0);
    do_load(3'd6, 16'b11_0101_01_11);
    chk("R5 burst 8", bl, 8);
    do_load(3'd6, 16'b00_0011_10_01);
    chk("R5 code00 keeps 8", bl, 8);
    chk("R5 other fields update", trfc, 3);

    for (int n = 0; n < 40; n++) begin
      int sel;
      sel = $urandom % 3;
      if (sel == 0) do_load(3'd6, 16'($urandom % 1024));
      else do_mem(3'(1 + $urandom % 5), 16'($urandom), $urandom % 5, 0);
    end
    chk("R9 no false error", perr, 0);
    chk("R6 disabled no pend", pend, 0);

    // ignored commands
    do_mem(3'd1, 16'hBEEF, 3, 1);
    chk("R9 err set", perr, 1);
    check_cfg("R9 cfg unchanged");
    cmd = 3'd6; addr = 16'h0155;
    tick();
    m_cas = 1; m_trcd = 1; m_trfc = 5; m_blc = 1;
    cmd = 3'd1; addr = 16'h1111;
    tick();
    cmd = 3'd0;
    chk("R9 guard no req", req, 0);
    tick();
    chk("R9 guard cmd ignored", req, 0);
    check_cfg("R9 cfg after guard");
    repeat (3) tick();
    chk("R9 err sticky", perr, 1);

    // refresh timing
    reset_dut();
    cmd = 3'd7; addr = 16'd20;
    tick();
    cmd = 3'd0;
    repeat (19) tick();
    chk("R6 pend not yet", pend, 0);
    tick();
    chk("R6 pend at N+1", pend, 1);
    tick();
    chk("R7 ref req", req, 1);
    chk("R7 ref op", op, 3);
    chk("R7 no cmd ack", cmd_ack, 0);
    done = 1'b1;
    tick();
    done = 1'b0;
    chk("R7 ref_ack", rack, 1);
    chk("R7 pend cleared", pend, 0);
    chk("R7 no host ack", cmd_ack, 0);
    repeat (17) tick();
    chk("R6 period not yet", pend, 0);
    tick();
    chk("R6 periodic pend", pend, 1);
    cmd = 3'd1; addr = 16'h2222;
    tick();
    cmd = 3'd0;
    chk("R8 refresh wins", op, 3);
    chk("R8 req", req, 1);
    chk("R8 err", perr, 1);
    done = 1'b1;
    tick();
    done = 1'b0;
    chk("R8 ref_ack", rack, 1);
    do_load(3'd7, 16'd0);
    for (int i = 0; i < 60; i++) begin
      tick();
      if (pend) chk("R6 disabled", pend, 0);
    end
    chk("R6 disabled end", pend, 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule